// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block is the register front end for a pair of cascaded priority interrupt controllers, a primary and a secondary. It watches byte-wide I/O writes and reads. Each controller owns two adjacent addresses: a command address at its base, and a data address at base+1. The block runs the initialization word sequence for each controller and holds the resulting configuration words. It keeps the mask, lowest-priority, special-mask and read-select state that later command words change. It also returns register contents on reads.

Writing the command address with data bit 4 set starts initialization. This also forces a defined mask, priority, slave address and read-select state. Exactly three data-address writes must follow, and they are stored in turn as the second, third and fourth initialization words. After the fourth word the controller is ready. From then on, data-address writes load the mask, and command-address writes with bit 4 clear are treated as operation words.

Request resolution, arbitration and acknowledge cycles belong to the interrupt core. That core takes its configuration from this block's outputs and supplies the request and in-service registers for reads.

Top module: `pic_init_front`

## Requirements
- R1: Controller 0 decodes base 0x020 and controller 1 decodes base 0xA0. Address bit 0 = 0 selects the command address and bit 0 = 1 selects the data address. Accesses to any other address change no state, and a read of any other address returns 0x00.
- R2: A command-address write with data bit 4 = 1 is an initialization start from any state. It stores the byte in `icw1_o`. The next data-address write is then taken as the second word, even when a sequence was already in progress.
- R3: After a start, the first three data-address writes are stored in this fixed order: `icw2_o`, then `icw3_o`, then `icw4_o`.
- R4: `ready_o` is 0 from a start until the third data-address write, and it is 1 from the cycle after that write.
- R5: A start clears all eight bits of `mask_o`.
- R6: A start sets `prio_low_o` (the input with lowest priority) to 7.
- R7: A start sets `slave_id_o` to 7. The write stored as `icw3_o` then loads `slave_id_o` from its bits 2:0.
- R8: A start sets `smm_o` to 0 and `rd_isr_o` to 0, so that command-address reads return the request register.
- R9: While ready, a data-address write loads `mask_o`. A data-address read returns `mask_o`.
- R10: While ready, a command-address write with bit 4 = 0 and bit 3 = 0 raises `ocw2_stb_o` during that write. If bits 7:5 equal 3'b110, it also sets `prio_low_o` to bits 2:0. Other values of bits 7:5 leave `prio_low_o` unchanged.
- R11: While ready, a command-address write with bit 4 = 0 and bit 3 = 1 is a third operation word. If bit 1 = 1, bit 0 loads `rd_isr_o`. If bit 6 = 1, bit 5 loads `smm_o`. A command-address read returns `isr_i` when `rd_isr_o` = 1 and `irr_i` otherwise.
- R12: Before the first start, data-address writes and command-address writes with bit 4 = 0 have no effect. Between a start and ready, command-address writes with bit 4 = 0 have no effect.
- R13: After reset, each controller waits for a start, with `ready_o` = 0, the stored initialization words at 0x00, and mask, priority, slave address, special-mask and read-select state equal to what a start sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_wr_i | input | 1 | I/O write strobe, one cycle per write |
| io_rd_i | input | 1 | I/O read strobe, ignored while io_wr_i is set |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, combinational from address and state |
| irr_i | input | 16 | Request registers from the core, controller n at bits 8n+7:8n |
| isr_i | input | 16 | In-service registers from the core, same layout |
| ready_o | output | 2 | Controller has finished initialization |
| icw1_o | output | 16 | Stored start word per controller |
| icw2_o | output | 16 | Stored second word (vector base) per controller |
| icw3_o | output | 16 | Stored third word (cascade) per controller |
| icw4_o | output | 16 | Stored fourth word (mode) per controller |
| mask_o | output | 16 | Interrupt mask per controller |
| prio_low_o | output | 6 | Lowest-priority input, 3 bits per controller |
| slave_id_o | output | 6 | Slave address, 3 bits per controller |
| smm_o | output | 2 | Special mask mode per controller |
| rd_isr_o | output | 2 | Read select per controller, 1 = in-service |
| ocw2_stb_o | output | 2 | Second operation word strobe, data on io_wdata_i |

## Verification
The bench restarts a sequence after a single data write and then checks that the next three words land in the second, third and fourth slots. A design that resumed the old sequence would store the second word as the cascade word. Before any start, it sends command-address writes with bit 4 clear and stray data writes, and then checks that neither mask nor read select moved. A design that honoured operation words too early would change them. It also drives addresses that differ from a base only in high bits. A decoder that compared too few bits would accept these and corrupt the mask. Finally, every mask value and every priority rotation value is swept on both controllers, and a start is made from a fully altered state so that each of its side effects is seen on its own.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;
  typedef enum logic [2:0] {
    S_WAIT_START,
    S_WAIT_W2,
    S_WAIT_W3,
    S_WAIT_W4,
    S_READY
  } seq_state_e;

  typedef struct packed {
    logic cmd_wr;
    logic dat_wr;
    logic cmd_rd;
    logic dat_rd;
  } acc_t;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 3;
endpackage

// File: rtl/pic_addr_dec.sv
module pic_addr_dec
  import pic_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_t              acc_o
);
  logic hit;

  // pair of addresses: bit 0 chooses command or data
  assign hit = (addr_i[ADDR_W-1:1] == BASE[ADDR_W-1:1]);

  always_comb begin
    acc_o        = '0;
    acc_o.cmd_wr = wr_i & hit & ~addr_i[0];
    acc_o.dat_wr = wr_i & hit &  addr_i[0];
    acc_o.cmd_rd = rd_i & ~wr_i & hit & ~addr_i[0];
    acc_o.dat_rd = rd_i & ~wr_i & hit &  addr_i[0];
  end
endmodule

// File: rtl/pic_icw_fsm.sv
module pic_icw_fsm
  import pic_init_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic              dat_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              start_o,
  output logic              ocw1_o,
  output logic              ocw2_o,
  output logic              ocw3_o,
  output logic [BYTE_W-1:0] icw1_o,
  output logic [BYTE_W-1:0] icw2_o,
  output logic [BYTE_W-1:0] icw3_o,
  output logic [BYTE_W-1:0] icw4_o,
  output logic [IDX_W-1:0]  slave_id_o
);
  seq_state_e state_q;
  logic       is_ready;

  assign is_ready = (state_q == S_READY);
  assign ready_o  = is_ready;
  assign start_o  = cmd_wr_i & wdata_i[4];
  assign ocw1_o   = dat_wr_i & is_ready;
  assign ocw2_o   = cmd_wr_i & ~wdata_i[4] & ~wdata_i[3] & is_ready;
  assign ocw3_o   = cmd_wr_i & ~wdata_i[4] &  wdata_i[3] & is_ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_WAIT_START;
      icw1_o     <= '0;
      icw2_o     <= '0;
      icw3_o     <= '0;
      icw4_o     <= '0;
      slave_id_o <= '1;
    end else if (start_o) begin
      state_q    <= S_WAIT_W2;
      icw1_o     <= wdata_i;
      slave_id_o <= '1;
    end else if (dat_wr_i) begin
      unique case (state_q)
        S_WAIT_W2: begin
          icw2_o  <= wdata_i;
          state_q <= S_WAIT_W3;
        end
        S_WAIT_W3: begin
          icw3_o     <= wdata_i;
          slave_id_o <= wdata_i[IDX_W-1:0];
          state_q    <= S_WAIT_W4;
        end
        S_WAIT_W4: begin
          icw4_o  <= wdata_i;
          state_q <= S_READY;
        end
        default: state_q <= state_q;
      endcase
    end
  end

  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (state_q == S_WAIT_W2));
  a_r4_ready_after_w4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(is_ready) |-> $past(state_q == S_WAIT_W4 && dat_wr_i));
  a_r7_slave_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (slave_id_o == 3'd7));
  a_r3_icw2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_WAIT_W2) |=> $stable(icw2_o));
endmodule

// File: rtl/pic_ocw_regs.sv
module pic_ocw_regs
  import pic_init_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ocw1_i,
  input  logic              ocw2_i,
  input  logic              ocw3_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] mask_o,
  output logic [IDX_W-1:0]  prio_low_o,
  output logic              smm_o,
  output logic              rd_isr_o
);
  logic [1:0] unused_bits;
  assign unused_bits = wdata_i[4:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o     <= '0;
      prio_low_o <= '1;
      smm_o      <= 1'b0;
      rd_isr_o   <= 1'b0;
    end else if (start_i) begin
      mask_o     <= '0;
      prio_low_o <= '1;
      smm_o      <= 1'b0;
      rd_isr_o   <= 1'b0;
    end else begin
      if (ocw1_i) mask_o <= wdata_i;
      if (ocw2_i && wdata_i[7:5] == 3'b110) prio_low_o <= wdata_i[IDX_W-1:0];
      if (ocw3_i) begin
        if (wdata_i[1]) rd_isr_o <= wdata_i[0];
        if (wdata_i[6]) smm_o    <= wdata_i[5];
      end
    end
  end

  a_r5_mask_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (mask_o == '0));
  a_r6_prio_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (prio_low_o == 3'd7));
  a_r8_read_sel_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!smm_o && !rd_isr_o));
  a_r9_mask_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mask_o) |-> $past(ocw1_i || start_i));
  a_r10_prio_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prio_low_o) |-> $past(ocw2_i || start_i));
endmodule

// File: rtl/pic_init_front.sv
module pic_init_front
  import pic_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NCTL   = 2,
  parameter logic [NCTL*ADDR_W-1:0] BASES = {16'h00A0, 16'h0020}
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   io_wr_i,
  input  logic                   io_rd_i,
  input  logic [ADDR_W-1:0]      io_addr_i,
  input  logic [BYTE_W-1:0]      io_wdata_i,
  output logic [BYTE_W-1:0]      io_rdata_o,
  input  logic [NCTL*BYTE_W-1:0] irr_i,
  input  logic [NCTL*BYTE_W-1:0] isr_i,
  output logic [NCTL-1:0]        ready_o,
  output logic [NCTL*BYTE_W-1:0] icw1_o,
  output logic [NCTL*BYTE_W-1:0] icw2_o,
  output logic [NCTL*BYTE_W-1:0] icw3_o,
  output logic [NCTL*BYTE_W-1:0] icw4_o,
  output logic [NCTL*BYTE_W-1:0] mask_o,
  output logic [NCTL*IDX_W-1:0]  prio_low_o,
  output logic [NCTL*IDX_W-1:0]  slave_id_o,
  output logic [NCTL-1:0]        smm_o,
  output logic [NCTL-1:0]        rd_isr_o,
  output logic [NCTL-1:0]        ocw2_stb_o
);
  acc_t              acc   [NCTL];
  logic [BYTE_W-1:0] mask_w[NCTL];
  logic [NCTL-1:0]   hit_v;

  for (genvar g = 0; g < NCTL; g++) begin : g_ctl
    logic start, ocw1, ocw2, ocw3;

    pic_addr_dec #(
      .ADDR_W(ADDR_W),
      .BASE  (BASES[g*ADDR_W +: ADDR_W])
    ) u_dec (
      .wr_i  (io_wr_i),
      .rd_i  (io_rd_i),
      .addr_i(io_addr_i),
      .acc_o (acc[g])
    );

    pic_icw_fsm u_fsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cmd_wr_i  (acc[g].cmd_wr),
      .dat_wr_i  (acc[g].dat_wr),
      .wdata_i   (io_wdata_i),
      .ready_o   (ready_o[g]),
      .start_o   (start),
      .ocw1_o    (ocw1),
      .ocw2_o    (ocw2),
      .ocw3_o    (ocw3),
      .icw1_o    (icw1_o[g*BYTE_W +: BYTE_W]),
      .icw2_o    (icw2_o[g*BYTE_W +: BYTE_W]),
      .icw3_o    (icw3_o[g*BYTE_W +: BYTE_W]),
      .icw4_o    (icw4_o[g*BYTE_W +: BYTE_W]),
      .slave_id_o(slave_id_o[g*IDX_W +: IDX_W])
    );

    pic_ocw_regs u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start),
      .ocw1_i    (ocw1),
      .ocw2_i    (ocw2),
      .ocw3_i    (ocw3),
      .wdata_i   (io_wdata_i),
      .mask_o    (mask_w[g]),
      .prio_low_o(prio_low_o[g*IDX_W +: IDX_W]),
      .smm_o     (smm_o[g]),
      .rd_isr_o  (rd_isr_o[g])
    );

    assign mask_o[g*BYTE_W +: BYTE_W] = mask_w[g];
    assign ocw2_stb_o[g] = ocw2;
    assign hit_v[g] = |acc[g];
  end

  always_comb begin
    io_rdata_o = '0;
    for (int i = 0; i < NCTL; i++) begin
      if (acc[i].dat_rd) io_rdata_o |= mask_w[i];
      if (acc[i].cmd_rd)
        io_rdata_o |= rd_isr_o[i] ? isr_i[i*BYTE_W +: BYTE_W]
                                  : irr_i[i*BYTE_W +: BYTE_W];
    end
  end

  a_r1_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_v));
  a_r1_miss_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && hit_v == '0) |-> (io_rdata_o == '0));
  a_r12_no_ocw_before_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocw2_stb_o & ~ready_o) == '0);
endmodule

// File: tb/pic_init_front_test.sv
`timescale 1ns/1ps
module pic_init_front_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [15:0] irr = 16'h5AA5, isr = 16'hC33C;
  logic [1:0]  ready, smm, rd_isr, ocw2_stb;
  logic [15:0] icw1, icw2, icw3, icw4, mask;
  logic [5:0]  prio_low, slave_id;
  int          n_run = 0, n_fail = 0;
  logic        stb_seen;
  bit          done = 0;

  pic_init_front uut (
    .clk_i(clk), .rst_ni(rst_ni), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .irr_i(irr), .isr_i(isr), .ready_o(ready), .icw1_o(icw1), .icw2_o(icw2),
    .icw3_o(icw3), .icw4_o(icw4), .mask_o(mask), .prio_low_o(prio_low),
    .slave_id_o(slave_id), .smm_o(smm), .rd_isr_o(rd_isr), .ocw2_stb_o(ocw2_stb)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] base(input int c);
    return (c == 0) ? 16'h0020 : 16'h00A0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    #1 stb_seen = |ocw2_stb;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic init(input int c, input logic [7:0] w2, w3, w4);
    wr(base(c), 8'h11);
    wr(base(c) + 1, w2);
    wr(base(c) + 1, w3);
    wr(base(c) + 1, w4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R13 reset state
    for (int c = 0; c < 2; c++) begin
      chk("R13 ready", ready[c], 0);
      chk("R13 mask", mask[c*8 +: 8], 0);
      chk("R13 prio", prio_low[c*3 +: 3], 7);
      chk("R13 slave", slave_id[c*3 +: 3], 7);
      chk("R13 smm", smm[c], 0);
      chk("R13 rdsel", rd_isr[c], 0);
      chk("R13 icw2", icw2[c*8 +: 8], 0);
    end
    // R12 ignored before first start
    wr(16'h0021, 8'h55);
    wr(16'h0020, 8'h0B);
    wr(16'h0020, 8'hC3);
    chk("R12 mask", mask[7:0], 0);
    chk("R12 icw2", icw2[7:0], 0);
    chk("R12 rdsel", rd_isr[0], 0);
    chk("R12 prio", prio_low[2:0], 7);
    rd(16'h0020, r);
    chk("R12 cmd read irr", r, 8'hA5);
    // R2 R3 R4 R7 initialization of both
    for (int c = 0; c < 2; c++) begin
      logic [7:0] v2, v3, v4;
      v2 = (c == 0) ? 8'h08 : 8'h70;
      v3 = (c == 0) ? 8'h04 : 8'h02;
      v4 = 8'h01;
      wr(base(c), 8'h11);
      chk("R2 icw1", icw1[c*8 +: 8], 8'h11);
      wr(base(c), 8'h0A);
      chk("R12 ocw3 before ready", rd_isr[c], 0);
      wr(base(c) + 1, v2);
      chk("R4 not ready after w2", ready[c], 0);
      wr(base(c) + 1, v3);
      chk("R7 slave from w3", slave_id[c*3 +: 3], v3[2:0]);
      chk("R4 not ready after w3", ready[c], 0);
      wr(base(c) + 1, v4);
      chk("R4 ready", ready[c], 1);
      chk("R3 icw2", icw2[c*8 +: 8], v2);
      chk("R3 icw3", icw3[c*8 +: 8], v3);
      chk("R3 icw4", icw4[c*8 +: 8], v4);
      chk("R5 mask after init", mask[c*8 +: 8], 0);
      if (c == 0) chk("R1 other ctl untouched", ready[1], 0);
    end
    // R9 exhaustive mask
    for (int c = 0; c < 2; c++)
      for (int v = 0; v < 256; v++) begin
        wr(base(c) + 1, v[7:0]);
        chk("R9 mask out", mask[c*8 +: 8], v);
        rd(base(c) + 1, r);
        chk("R9 mask read", r, v);
      end
    // R10 priority rotation sweep
    for (int c = 0; c < 2; c++) begin
      for (int p = 0; p < 8; p++) begin
        wr(base(c), 8'hC0 | p[7:0]);
        chk("R10 strobe", stb_seen, 1);
        chk("R10 prio", prio_low[c*3 +: 3], p);
      end
      wr(base(c), 8'h25);
      chk("R10 eoi strobe", stb_seen, 1);
      chk("R10 eoi keeps prio", prio_low[c*3 +: 3], 7);
      wr(base(c), 8'h0A);
      chk("R10 no strobe on ocw3", stb_seen, 0);
    end
    // R11 read select and special mask
    for (int c = 0; c < 2; c++) begin
      rd(base(c), r);
      chk("R11 irr read", r, irr[c*8 +: 8]);
      wr(base(c), 8'h0B);
      rd(base(c), r);
      chk("R11 isr read", r, isr[c*8 +: 8]);
      wr(base(c), 8'h08);
      chk("R11 rr=0 keeps", rd_isr[c], 1);
      wr(base(c), 8'h0A);
      rd(base(c), r);
      chk("R11 back to irr", r, irr[c*8 +: 8]);
      wr(base(c), 8'h68);
      chk("R11 smm set", smm[c], 1);
      wr(base(c), 8'h28);
      chk("R11 esmm=0 keeps", smm[c], 1);
      wr(base(c), 8'h48);
      chk("R11 smm clr", smm[c], 0);
    end
    // R5 R6 R7 R8 side effects of a start from altered state
    wr(16'h0021, 8'hFF);
    wr(16'h0020, 8'hC3);
    wr(16'h0020, 8'h6B);
    wr(16'h0020, 8'h13);
    chk("R5 mask clear", mask[7:0], 0);
    chk("R6 prio 7", prio_low[2:0], 7);
    chk("R7 slave 7", slave_id[2:0], 7);
    chk("R8 smm clr", smm[0], 0);
    chk("R8 rdsel irr", rd_isr[0], 0);
    chk("R4 not ready after start", ready[0], 0);
    chk("R1 ctl1 still ready", ready[1], 1);
    // R2 restart mid sequence
    wr(16'h0021, 8'h40);
    wr(16'h0020, 8'h11);
    wr(16'h0021, 8'h48);
    wr(16'h0021, 8'h07);
    chk("R2 restart not ready", ready[0], 0);
    wr(16'h0021, 8'h03);
    chk("R2 restart icw2", icw2[7:0], 8'h48);
    chk("R2 restart icw3", icw3[7:0], 8'h07);
    chk("R2 restart icw4", icw4[7:0], 8'h03);
    chk("R4 ready again", ready[0], 1);
    // R1 near-miss addresses
    wr(16'h0021, 8'h3C);
    wr(16'h0121, 8'hFF);
    wr(16'h0023, 8'hFF);
    wr(16'h00A3, 8'hFF);
    chk("R1 high-bit alias ignored", mask[7:0], 8'h3C);
    rd(16'h0022, r);
    chk("R1 miss read zero", r, 0);
    rd(16'h8021, r);
    chk("R1 alias read zero", r, 0);
    rd(16'h0021, r);
    chk("R1 hit read", r, 8'h3C);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule